// File: doc/BRIEF.md
# Over-Current Alarm Throttle Controller

This block watches a single over-current alarm line that arrives from outside the clock domain. The line is brought in through a two-stage synchronizer. A configuration bit then maps it to an internal "alarm active" level, so the line may be active-high or active-low. Each transition into the active level counts as one alarm event.

Events are counted against a programmable threshold. When the count reaches the threshold, a sticky interrupt flag is raised and the count starts again. An optional inactivity filter discards a partial count when no event has arrived for a programmed number of clocks.

Alongside the interrupt path, the block produces a throttle request. The request is active while the alarm is active and stays active for a programmed number of microseconds after the alarm goes away. It is presented together with the source's priority value, so a downstream arbiter can select among several sources. All configuration inputs are treated as static while alarms are in flight.

Top module: `oc_throttle_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), irq_flag is 0, throttle_active is 0 and throttle_priority is 0.
- R2: cfg_active_low = 1 makes alarm_in active when low; cfg_active_low = 0 makes it active when high. After alarm_in changes, throttle_active follows at the second rising clock edge (two synchronizer flops).
- R3: An event is a transition of the normalized alarm from inactive to active. An alarm held active for many cycles counts as one event.
- R4: On an event, the event count is incremented. irq_flag is set when the incremented count is greater than or equal to cfg_count_thresh, so the Nth event fires for threshold N. A threshold of 0 fires on every event.
- R5: The event count returns to zero in the cycle the interrupt fires, so a further N events are needed for the next interrupt.
- R6: With cfg_irq_en = 0, irq_flag is never set. Events are still counted, and the count saturates at its all-ones maximum instead of wrapping.
- R7: irq_flag stays at 1 until a one-cycle irq_clear pulse, which clears it at the next clock edge. A new firing event in the same cycle wins over the clear.
- R8: When cfg_filter_clks is nonzero, the event count is cleared once cfg_filter_clks clocks pass with no new event. Each event reloads the filter timer. A value of 0 disables the filter.
- R9: throttle_active is 1 while the synchronized alarm is active and for a further cfg_hold_us × CLKS_PER_US clocks after it deasserts. A hold of 0 releases the request at once.
- R10: throttle_priority equals cfg_priority whenever throttle_active is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alarm_in | input | 1 | Raw asynchronous over-current alarm line |
| cfg_active_low | input | 1 | 1 = alarm asserted low, 0 = asserted high |
| cfg_irq_en | input | 1 | Interrupt generation enable |
| cfg_count_thresh | input | CNT_W | Events needed per interrupt (0 = every event) |
| cfg_filter_clks | input | FILT_W | Inactivity clocks before the count is discarded (0 = off) |
| cfg_hold_us | input | PERIOD_W | Throttle stretch after deassertion, in microseconds |
| cfg_priority | input | PRIO_W | Priority presented with the throttle request |
| irq_clear | input | 1 | One-cycle pulse that clears irq_flag |
| throttle_active | output | 1 | Throttle request |
| throttle_priority | output | PRIO_W | Priority of the active request, 0 when idle |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The bench drives more than fifteen events into a four-bit counter with interrupts disabled, then enables them and sends one more event. A counter that wraps instead of saturating would then sit far below the threshold and stay silent. Events spaced closer than the filter window must still reach the threshold, which catches a filter that is not reloaded on each event. A gap longer than the window must lose the partial count.

The length of the throttle stretch is measured in clocks for both a nonzero hold and a zero hold, so an off-by-one in the prescaler or the hold counter shows up as a wrong count. Further tests check that a held alarm counts as one event and that firing restarts the count. A count left intact after firing would raise the next interrupt one event early.

// File: rtl/oc_throttle_pkg.sv
// Shared constants and types for the over-current throttle controller.
// Assumes: nothing beyond standard SystemVerilog.
package oc_throttle_pkg;
    localparam int unsigned OC_SYNC_STAGES  = 2;
    localparam int unsigned OC_PRIME_STAGES = OC_SYNC_STAGES + 1;

    typedef enum logic {
        OC_ACT_HIGH = 1'b0,
        OC_ACT_LOW  = 1'b1
    } oc_pol_e;
endpackage

// File: rtl/oc_alarm_front.sv
// Alarm front end: synchronizes the raw alarm, applies polarity and flags
// the transition into the active level as a one-cycle event.
// Assumes: alarm_raw may be asynchronous; pol_sel is static.
// No level or event is reported until the synchronizer holds real samples.
module oc_alarm_front
    import oc_throttle_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    alarm_raw,
    input  oc_pol_e pol_sel,
    output logic    alarm_lvl,
    output logic    alarm_evt
);
    logic [OC_SYNC_STAGES-1:0]  sync_q;
    logic [OC_PRIME_STAGES-1:0] prime_q;
    logic                       norm_lvl;
    logic                       lvl_q;

    // Synchronizer chain, one flop per stage.
    for (genvar i = 0; i < OC_SYNC_STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else        sync_q[i] <= alarm_raw;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else        sync_q[i] <= sync_q[i-1];
            end
        end
    end

    // Tracks how many edges since reset, to mask stale synchronizer contents.
    always_ff @(posedge clk) begin
        if (!rst_n) prime_q <= '0;
        else        prime_q <= {prime_q[OC_PRIME_STAGES-2:0], 1'b1};
    end

    // Previous normalized level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= norm_lvl;
    end

    // Polarity mapping and event detection.
    always_comb begin
        norm_lvl  = sync_q[OC_SYNC_STAGES-1] ^ (pol_sel == OC_ACT_LOW);
        alarm_lvl = prime_q[OC_SYNC_STAGES-1] & norm_lvl;
        alarm_evt = prime_q[OC_PRIME_STAGES-1] & norm_lvl & ~lvl_q;
    end

    // R3
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |=> !alarm_evt);
    // R3
    evt_needs_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |-> alarm_lvl);
endmodule

// File: rtl/oc_event_counter.sv
// Event counter with threshold compare, inactivity filter and sticky
// interrupt flag.
// Assumes: evt is a one-cycle pulse; configuration inputs are static.
// The count saturates at all-ones and returns to zero when the interrupt fires.
module oc_event_counter #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned FILT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic              irq_en,
    input  logic [CNT_W-1:0]  thresh,
    input  logic [FILT_W-1:0] filt_clks,
    input  logic              irq_clear,
    output logic              irq_flag
);
    localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [FILT_W-1:0] FILT_ONE = FILT_W'(1);

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_inc;
    logic [FILT_W-1:0] filt_q;
    logic              hit;
    logic              filt_expire;
    logic              irq_q;

    // Saturating increment, threshold compare and filter expiry.
    always_comb begin
        cnt_inc     = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
        hit         = irq_en && (cnt_inc >= thresh);
        filt_expire = (filt_q == FILT_ONE) && !evt;
    end

    // Event count: advance on event, restart on fire, clear on filter expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (evt)         cnt_q <= hit ? '0 : cnt_inc;
        else if (filt_expire) cnt_q <= '0;
    end

    // Inactivity timer: reloaded by each event, runs down to zero and rests.
    always_ff @(posedge clk) begin
        if (!rst_n)              filt_q <= '0;
        else if (evt)            filt_q <= filt_clks;
        else if (filt_q != '0)   filt_q <= filt_q - 1'b1;
    end

    // Sticky interrupt flag; a firing event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          irq_q <= 1'b0;
        else if (evt && hit) irq_q <= 1'b1;
        else if (irq_clear)  irq_q <= 1'b0;
    end

    assign irq_flag = irq_q;

    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(evt && irq_en));
    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !irq_en && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
    // R7
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clear && !evt) |=> !irq_q);
    // R8
    filt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q == FILT_ONE && !evt) |=> cnt_q == '0);
    // R5
    fire_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && irq_en && !irq_q) ##1 $rose(irq_q) |-> cnt_q == '0);
endmodule

// File: rtl/oc_hold_timer.sv
// Throttle stretch timer: after the alarm level drops, stays busy for
// hold_us microseconds, counted with a CLKS_PER_US prescaler.
// Assumes: hold_us is static; CLKS_PER_US >= 1.
module oc_hold_timer #(
    parameter int unsigned PERIOD_W    = 16,
    parameter int unsigned CLKS_PER_US = 100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lvl,
    input  logic [PERIOD_W-1:0] hold_us,
    output logic                hold_busy
);
    localparam int unsigned PRE_W    = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam int unsigned PRE_LAST = CLKS_PER_US - 1;

    logic [PERIOD_W-1:0] hold_q;
    logic                us_tick;

    if (CLKS_PER_US > 1) begin : g_pre
        logic [PRE_W-1:0] pre_q;
        // Microsecond prescaler, held at zero while alarmed or idle.
        always_ff @(posedge clk) begin
            if (!rst_n || lvl || hold_q == '0) pre_q <= '0;
            else if (pre_q == PRE_W'(PRE_LAST)) pre_q <= '0;
            else                                pre_q <= pre_q + 1'b1;
        end
        assign us_tick = (pre_q == PRE_W'(PRE_LAST));
    end else begin : g_nopre
        assign us_tick = 1'b1;
    end

    // Remaining microseconds: reloaded while alarmed, counted down after.
    always_ff @(posedge clk) begin
        if (!rst_n)                         hold_q <= '0;
        else if (lvl)                       hold_q <= hold_us;
        else if (hold_q != '0 && us_tick)   hold_q <= hold_q - 1'b1;
    end

    assign hold_busy = (hold_q != '0);

    // R9
    hold_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl && hold_q != '0) |=> hold_q <= $past(hold_q));
    // R9
    hold_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl && hold_q == '0) |=> hold_q == '0);
endmodule

// File: rtl/oc_throttle_ctrl.sv
// Over-current alarm throttle controller top: alarm front end, event
// counter with interrupt, and throttle stretch timer.
// Assumes: all cfg_* inputs are static while alarms are in flight.
module oc_throttle_ctrl
    import oc_throttle_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned FILT_W      = 24,
    parameter int unsigned PERIOD_W    = 16,
    parameter int unsigned PRIO_W      = 8,
    parameter int unsigned CLKS_PER_US = 100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alarm_in,
    input  logic                cfg_active_low,
    input  logic                cfg_irq_en,
    input  logic [CNT_W-1:0]    cfg_count_thresh,
    input  logic [FILT_W-1:0]   cfg_filter_clks,
    input  logic [PERIOD_W-1:0] cfg_hold_us,
    input  logic [PRIO_W-1:0]   cfg_priority,
    input  logic                irq_clear,
    output logic                throttle_active,
    output logic [PRIO_W-1:0]   throttle_priority,
    output logic                irq_flag
);
    logic alarm_lvl;
    logic alarm_evt;
    logic hold_busy;

    oc_alarm_front u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .alarm_raw (alarm_in),
        .pol_sel   (oc_pol_e'(cfg_active_low)),
        .alarm_lvl (alarm_lvl),
        .alarm_evt (alarm_evt)
    );

    oc_event_counter #(
        .CNT_W  (CNT_W),
        .FILT_W (FILT_W)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (alarm_evt),
        .irq_en    (cfg_irq_en),
        .thresh    (cfg_count_thresh),
        .filt_clks (cfg_filter_clks),
        .irq_clear (irq_clear),
        .irq_flag  (irq_flag)
    );

    oc_hold_timer #(
        .PERIOD_W    (PERIOD_W),
        .CLKS_PER_US (CLKS_PER_US)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl       (alarm_lvl),
        .hold_us   (cfg_hold_us),
        .hold_busy (hold_busy)
    );

    // Throttle request and its priority tag.
    always_comb begin
        throttle_active   = alarm_lvl | hold_busy;
        throttle_priority = throttle_active ? cfg_priority : '0;
    end

    // R9
    rise_from_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(throttle_active) |-> alarm_lvl);
    // R10
    prio_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(throttle_active) |-> throttle_priority == '0);
endmodule

// File: tb/sim_oc_throttle_ctrl.sv
module sim_oc_throttle_ctrl;
    localparam int CNT_W = 4, FILT_W = 12, PERIOD_W = 8, PRIO_W = 8, CPU = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alarm_in = 1'b0;
    logic cfg_active_low = 1'b0;
    logic cfg_irq_en = 1'b1;
    logic [CNT_W-1:0] cfg_count_thresh = '0;
    logic [FILT_W-1:0] cfg_filter_clks = '0;
    logic [PERIOD_W-1:0] cfg_hold_us = '0;
    logic [PRIO_W-1:0] cfg_priority = '0;
    logic irq_clear = 1'b0;
    logic throttle_active;
    logic [PRIO_W-1:0] throttle_priority;
    logic irq_flag;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    oc_throttle_ctrl #(.CNT_W(CNT_W), .FILT_W(FILT_W), .PERIOD_W(PERIOD_W),
                       .PRIO_W(PRIO_W), .CLKS_PER_US(CPU)) u0 (
        .clk(clk), .rst_n(rst_n), .alarm_in(alarm_in),
        .cfg_active_low(cfg_active_low), .cfg_irq_en(cfg_irq_en),
        .cfg_count_thresh(cfg_count_thresh), .cfg_filter_clks(cfg_filter_clks),
        .cfg_hold_us(cfg_hold_us), .cfg_priority(cfg_priority),
        .irq_clear(irq_clear), .throttle_active(throttle_active),
        .throttle_priority(throttle_priority), .irq_flag(irq_flag)
    );

    // fields: en[14] al[13] thresh[12:9] events[8:1] expected irq[0]
    localparam logic [14:0] VEC [8] = '{
        {1'b1, 1'b0, 4'd0, 8'd1, 1'b1},
        {1'b1, 1'b1, 4'd0, 8'd1, 1'b1},
        {1'b1, 1'b0, 4'd3, 8'd2, 1'b0},
        {1'b1, 1'b0, 4'd3, 8'd3, 1'b1},
        {1'b1, 1'b1, 4'd5, 8'd4, 1'b0},
        {1'b1, 1'b1, 4'd5, 8'd5, 1'b1},
        {1'b1, 1'b0, 4'd1, 8'd1, 1'b1},
        {1'b0, 1'b0, 4'd0, 8'd3, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        alarm_in = cfg_active_low;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic pulse();
        alarm_in = ~cfg_active_low;
        repeat (3) @(negedge clk);
        alarm_in = cfg_active_low;
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_irq();
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
    endtask

    task automatic measure_hold(output int n);
        n = 0;
        alarm_in = ~cfg_active_low;
        repeat (5) @(negedge clk);
        alarm_in = cfg_active_low;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            if (throttle_active) n++;
            else break;
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        int n;
        // R1 reset state
        do_reset();
        check("R1 irq", int'(irq_flag), 0);
        check("R1 throttle", int'(throttle_active), 0);
        check("R1 priority", int'(throttle_priority), 0);

        // Table walk: R4 thresholds, R2 polarity, R6 disable
        for (int v = 0; v < 8; v++) begin
            cfg_irq_en = VEC[v][14];
            cfg_active_low = VEC[v][13];
            cfg_count_thresh = VEC[v][12:9];
            cfg_filter_clks = '0;
            do_reset();
            for (int e = 0; e < int'(VEC[v][8:1]); e++) pulse();
            check(v == 7 ? "R6 table" : "R4 table", int'(irq_flag), int'(VEC[v][0]));
        end
        cfg_irq_en = 1'b1;

        // R2 active-low latency: two edges
        cfg_active_low = 1'b1;
        do_reset();
        check("R2 idle high inactive", int'(throttle_active), 0);
        alarm_in = 1'b0;
        @(negedge clk);
        check("R2 one edge", int'(throttle_active), 0);
        @(negedge clk);
        check("R2 two edges", int'(throttle_active), 1);
        alarm_in = 1'b1;
        repeat (4) @(negedge clk);
        check("R2 release", int'(throttle_active), 0);

        // R3 held alarm counts once
        cfg_active_low = 1'b0;
        cfg_count_thresh = 4'd2;
        do_reset();
        alarm_in = 1'b1;
        repeat (30) @(negedge clk);
        alarm_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R3 held once", int'(irq_flag), 0);
        pulse();
        check("R3 second event", int'(irq_flag), 1);

        // R7 sticky and clear
        repeat (20) @(negedge clk);
        check("R7 sticky", int'(irq_flag), 1);
        clear_irq();
        check("R7 cleared", int'(irq_flag), 0);

        // R5 restart after fire
        pulse();
        check("R5 one after fire", int'(irq_flag), 0);
        pulse();
        check("R5 two after fire", int'(irq_flag), 1);
        clear_irq();

        // R6 saturation: 20 events in a 4-bit counter while disabled
        cfg_irq_en = 1'b0;
        cfg_count_thresh = 4'd15;
        do_reset();
        for (int e = 0; e < 20; e++) pulse();
        check("R6 disabled", int'(irq_flag), 0);
        cfg_irq_en = 1'b1;
        pulse();
        check("R6 saturated", int'(irq_flag), 1);

        // R8 filter expiry loses the partial count
        cfg_count_thresh = 4'd2;
        cfg_filter_clks = 12'd20;
        do_reset();
        pulse();
        repeat (40) @(negedge clk);
        pulse();
        check("R8 expired", int'(irq_flag), 0);
        pulse();
        check("R8 within window", int'(irq_flag), 1);

        // R8 each event reloads the filter
        cfg_count_thresh = 4'd3;
        cfg_filter_clks = 12'd10;
        do_reset();
        pulse(); pulse(); pulse();
        check("R8 reload", int'(irq_flag), 1);

        // R8 filter of zero never clears
        cfg_count_thresh = 4'd2;
        cfg_filter_clks = '0;
        do_reset();
        pulse();
        repeat (200) @(negedge clk);
        pulse();
        check("R8 disabled filter", int'(irq_flag), 1);

        // R9 / R10 throttle stretch and priority
        cfg_hold_us = 8'd3;
        cfg_priority = 8'h5A;
        do_reset();
        alarm_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 priority active", int'(throttle_priority), 'h5A);
        alarm_in = 1'b0;
        repeat (3) @(negedge clk);
        measure_hold(n);
        check("R9 hold 3us", n, 1 + 3 * CPU);
        check("R10 priority idle", int'(throttle_priority), 0);
        cfg_hold_us = '0;
        measure_hold(n);
        check("R9 hold zero", n, 1);

        summary();
    end
endmodule